// File: doc/BRIEF.md
# Serial Register-Access Host Engine

This block drives framed register transactions over a four-wire serial link (serial clock, host-out data, host-in data, active-low chip select) against a byte-addressed register target. The requester presents a transaction type (write, read, both or neither), a start address and a byte count, then pulses a start input. The engine lowers chip select and sends a command byte, then an address byte, then the data bytes. It releases chip select either after the encoded count or, in streaming mode, after the byte the requester marked as last.

Outgoing data bytes are pulled from the requester one at a time. Each time the engine latches `wr_data` and `wr_last` it pulses `wr_take`, and the requester then presents the next byte. Bytes received during the data phase come back on `rd_data` with a one-cycle `rd_valid` strobe. `done` pulses once when chip select is released. The serial clock follows mode 0: it idles low, host output changes on the falling edge and input is sampled on the rising edge. Its rate is set by a divider input.

Top module: `spi_reg_host`

## Requirements
- R1: The first byte sent in every frame is the command byte: bit 7 = write flag, bit 6 = read flag, bits 5:3 = `req_len`, bits 2:0 = 0. All bytes in both directions are shifted most significant bit first.
- R2: For any command other than no-operation, an address byte equal to `req_addr` follows the command byte, and data bytes follow the address. Each data byte sent is the `wr_data` value latched for it when the write flag is set, and 0x00 when the write flag is clear.
- R3: When `req_len` is 1 to 7, exactly that many data bytes are sent and then chip select is released. `wr_last` has no effect in this mode.
- R4: When `req_len` is 0 (streaming), data bytes continue until the byte that was latched with `wr_last` = 1 has been sent.
- R5: When both the read and write flags are 0, only the command byte is sent before chip select is released.
- R6: When the read flag is set, each data byte received on `sdi` is presented on `rd_data` with a one-cycle `rd_valid` pulse. When the read flag is clear, `rd_valid` never pulses.
- R7: `sck` idles low and has a period of 2*(`div_cfg`+1) clock cycles during a frame. `sdi` is sampled on its rising edge. `sdo` changes only while `sck` is low.
- R8: Chip select falls at least `div_cfg`+1 cycles before the first rising `sck` edge and rises at least `div_cfg`+1 cycles after the last falling edge. `done` pulses for one cycle, exactly once per frame, as chip select rises.
- R9: After reset `cs_n`=1, `sck`=0, `busy`=0 and `done`=0. A `req_start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W | Half-period of sck minus one, in clk cycles |
| req_start | input | 1 | Start pulse, accepted when idle |
| req_write | input | 1 | Write flag of the transaction |
| req_read | input | 1 | Read flag of the transaction |
| req_len | input | 3 | Data byte count, 0 = streaming |
| req_addr | input | 8 | Start register address |
| wr_data | input | 8 | Next outgoing data byte |
| wr_last | input | 1 | Marks wr_data as the final streaming byte |
| wr_take | output | 1 | Pulses after wr_data/wr_last were latched |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at chip select release |
| sck | output | 1 | Serial clock, mode 0 |
| sdo | output | 1 | Host-to-target serial data |
| sdi | input | 1 | Target-to-host serial data |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong bit or phase counter shows up at once as a wrong number of serial clock edges or bytes in the frame, so the byte stream a bench-side target captures differs within the same frame. A corrupt command or address register shows as a wrong first or second captured byte. A stuck read-mode or last-byte flag shows as missing or extra `rd_valid` strobes, or as a frame that ends early or late. A faulty divider shows as a wrong spacing between clock edges, measured from the first full period onward.

// File: rtl/spi_reg_host.sv
module spi_reg_host #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             req_start,
  input  logic             req_write,
  input  logic             req_read,
  input  logic [2:0]       req_len,
  input  logic [7:0]       req_addr,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             sdo,
  input  logic             sdi,
  output logic             cs_n
);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;
  localparam logic [1:0] PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [7:0]       txs, rxs, addr_q;
  logic [2:0]       bitn, left;
  logic [1:0]       phase;
  logic             mode_w, mode_r, stream, last_q;
  logic             sck_q, cs_q, take_q, rdv_q, done_q;
  logic [7:0]       rdd_q;

  wire tick = (cnt == div_cfg);
  wire fin  = stream ? last_q : (left == 3'd1);

  assign sck      = sck_q;
  assign cs_n     = cs_q;
  assign sdo      = txs[7];
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign wr_take  = take_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; txs <= '0; rxs <= '0; addr_q <= '0;
      bitn <= '0; left <= '0; phase <= PH_CMD;
      mode_w <= 1'b0; mode_r <= 1'b0; stream <= 1'b0; last_q <= 1'b0;
      sck_q <= 1'b0; cs_q <= 1'b1; take_q <= 1'b0; rdv_q <= 1'b0;
      done_q <= 1'b0; rdd_q <= '0;
    end else begin
      take_q <= 1'b0;
      rdv_q  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= (st == S_IDLE || tick) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (req_start) begin
          st     <= S_LEAD;
          cs_q   <= 1'b0;
          txs    <= {req_write, req_read, req_len, 3'b000};
          addr_q <= req_addr;
          mode_w <= req_write;
          mode_r <= req_read;
          stream <= (req_len == 3'd0);
          left   <= req_len;
          phase  <= PH_CMD;
          bitn   <= '0;
        end
        S_LEAD: if (tick) begin
          st    <= S_SHIFT;
          sck_q <= 1'b1;
          rxs   <= {rxs[6:0], sdi};
        end
        S_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rxs   <= {rxs[6:0], sdi};
          end else begin
            sck_q <= 1'b0;
            bitn  <= bitn + 1'b1;
            if (bitn != 3'd7) begin
              txs <= {txs[6:0], 1'b0};
            end else begin
              case (phase)
                PH_CMD: begin
                  if (!mode_w && !mode_r) st <= S_TRAIL;
                  else begin txs <= addr_q; phase <= PH_ADDR; end
                end
                PH_ADDR: begin
                  txs    <= mode_w ? wr_data : 8'h00;
                  last_q <= wr_last;
                  take_q <= 1'b1;
                  phase  <= PH_DATA;
                end
                default: begin
                  rdv_q <= mode_r;
                  rdd_q <= rxs;
                  if (fin) st <= S_TRAIL;
                  else begin
                    txs    <= mode_w ? wr_data : 8'h00;
                    last_q <= wr_last;
                    take_q <= 1'b1;
                    left   <= left - 1'b1;
                  end
                end
              endcase
            end
          end
        end
        S_TRAIL: if (tick) begin
          st     <= S_IDLE;
          cs_q   <= 1'b1;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sck_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !cs_q);
  p_sck_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> $past(tick));
  p_sdo_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sck_q) && sck_q) |-> $stable(txs[7]));
  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> done_q);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_rd_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> (mode_r && !cs_q));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> $stable(addr_q) && $stable(mode_w) && $stable(mode_r));

endmodule

// File: tb/test_spi_reg_host.sv
`timescale 1ns/1ps
module test_spi_reg_host;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_cfg = 8'd0;
  logic       req_start = 1'b0, req_write = 1'b0, req_read = 1'b0;
  logic [2:0] req_len = 3'd0;
  logic [7:0] req_addr = 8'd0;
  logic [7:0] wr_data;
  logic       wr_last;
  logic       wr_take, rd_valid, busy, done, sck, sdo, cs_n;
  logic [7:0] rd_data;
  logic       sdi = 1'b0;

  always #2 clk = ~clk;

  spi_reg_host #(.DIV_W(8)) i_spi_reg_host (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_start(req_start),
    .req_write(req_write), .req_read(req_read), .req_len(req_len),
    .req_addr(req_addr), .wr_data(wr_data), .wr_last(wr_last),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .sck(sck), .sdo(sdo), .sdi(sdi), .cs_n(cs_n));

  int n_tests = 0, n_fail = 0;
  int take_cnt = 0, stream_n = 1;
  logic [7:0] salt = 8'h00;

  function automatic logic [7:0] wd(int j);
    return (8'hC3 ^ salt) + 8'(j) * 8'd17;
  endfunction
  function automatic logic [7:0] mi(int k);
    return 8'h5A ^ (8'(k) * 8'd29);
  endfunction

  assign wr_data = wd(take_cnt);
  assign wr_last = (take_cnt == stream_n - 1);

  always @(posedge clk)
    if (req_start && !busy) take_cnt <= 0;
    else if (wr_take) take_cnt <= take_cnt + 1;

  logic [7:0] rxb [0:15];
  logic [7:0] rdb [0:15];
  int rx_n, sbit, rd_n, nrise, bad_gap, bad_sdo, done_n, exp_gap;
  logic [7:0] sh;
  longint t_cs_fall, t_first_rise, t_last_rise, t_last_fall, t_cs_rise;

  always @(negedge cs_n) begin
    sbit = 0; rx_n = 0; nrise = 0; t_cs_fall = $time; sdi = mi(0)[7];
  end
  always @(posedge cs_n) t_cs_rise = $time;
  always @(posedge sck) if (!cs_n) begin
    if (nrise == 0) t_first_rise = $time;
    else if ($time - t_last_rise != exp_gap) bad_gap++;
    t_last_rise = $time;
    nrise++;
    sh = {sh[6:0], sdo};
    sbit++;
    if (sbit == 8) begin
      if (rx_n < 16) rxb[rx_n] = sh;
      rx_n++; sbit = 0;
    end
  end
  always @(negedge sck) if (!cs_n) begin
    t_last_fall = $time;
    sdi = mi(rx_n)[7 - sbit];
  end

  logic psck = 1'b0, psdo = 1'b0;
  always @(negedge clk) begin
    if (psck && sck && sdo != psdo) bad_sdo++;
    psck = sck; psdo = sdo;
    if (rd_valid) begin
      if (rd_n < 16) rdb[rd_n] = rd_data;
      rd_n++;
    end
    if (done) done_n++;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic w, input logic r, input logic [2:0] len,
                         input logic [7:0] addr, input int sn, input logic [7:0] dv,
                         input logic poke);
    int nb, to, nbytes;
    logic [7:0] cmd;
    cmd = {w, r, len, 3'b000};
    nb = (!w && !r) ? 0 : (len == 0 ? sn : int'(len));
    nbytes = (!w && !r) ? 1 : 2 + nb;
    @(negedge clk);
    div_cfg = dv; stream_n = sn; salt = 8'($urandom);
    exp_gap = 2 * (int'(dv) + 1) * 4;
    rd_n = 0; bad_gap = 0; bad_sdo = 0; done_n = 0;
    req_write = w; req_read = r; req_len = len; req_addr = addr; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    to = 0;
    while (done_n == 0 && to < 20000) begin
      @(negedge clk);
      to++;
      if (poke && to == 30) begin
        req_write = ~w; req_read = ~r; req_len = len + 3'd1; req_addr = ~addr; req_start = 1'b1;
      end else req_start = 1'b0;
    end
    chk(to < 20000, "R8 frame completes (watchdog)", to, 20000);
    repeat (4) @(negedge clk);
    chk(done_n == 1, "R8 single done pulse", done_n, 1);
    chk(rx_n == nbytes, poke ? "R9 start while busy ignored, byte count" :
        (!w && !r) ? "R5 nop byte count" : (len == 0 ? "R4 streaming byte count" : "R3 counted byte count"),
        rx_n, nbytes);
    chk(rxb[0] == cmd, "R1 command byte", rxb[0], cmd);
    if (nbytes > 1 && rx_n >= 2) chk(rxb[1] == addr, "R2 address byte", rxb[1], addr);
    for (int j = 0; j < nb && j + 2 < rx_n && j + 2 < 16; j++)
      chk(rxb[j+2] == (w ? wd(j) : 8'h00), "R2 data byte", rxb[j+2], w ? wd(j) : 8'h00);
    chk(rd_n == (r ? nb : 0), "R6 read strobe count", rd_n, r ? nb : 0);
    for (int j = 0; j < rd_n && j < 16; j++)
      chk(rdb[j] == mi(j + 2), "R6 read data", rdb[j], mi(j + 2));
    chk(bad_gap == 0 && nrise == 8 * rx_n, "R7 sck period and edge count", bad_gap, 0);
    chk(bad_sdo == 0, "R7 sdo stable while sck high", bad_sdo, 0);
    chk(t_first_rise - t_cs_fall >= (int'(dv) + 1) * 4, "R8 lead time",
        t_first_rise - t_cs_fall, (int'(dv) + 1) * 4);
    chk(t_cs_rise - t_last_fall >= (int'(dv) + 1) * 4, "R8 trail time",
        t_cs_rise - t_last_fall, (int'(dv) + 1) * 4);
    chk(cs_n && !sck && !busy, "R7 idle levels after frame", {cs_n, sck, busy}, 3'b100);
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R9 reset state",
        {cs_n, sck, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 1'b0, 3'd0, 8'h10, 1, 8'd1, 1'b0);
    run_txn(1'b0, 1'b0, 3'd4, 8'h10, 1, 8'd0, 1'b0);
    run_txn(1'b1, 1'b0, 3'd7, 8'h04, 2, 8'd0, 1'b0);
    run_txn(1'b0, 1'b1, 3'd0, 8'hFF, 1, 8'd2, 1'b0);
    run_txn(1'b1, 1'b1, 3'd0, 8'h80, 5, 8'd1, 1'b0);
    run_txn(1'b1, 1'b1, 3'd1, 8'h33, 3, 8'd0, 1'b0);
    run_txn(1'b0, 1'b1, 3'd2, 8'h07, 1, 8'd5, 1'b0);
    run_txn(1'b1, 1'b0, 3'd3, 8'h42, 1, 8'd1, 1'b1);
    for (int i = 0; i < 30; i++)
      run_txn(1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
              1 + int'($urandom % 6), 8'($urandom % 4), 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule